// File: doc/BRIEF.md
# Calibrated Seconds Divider with Frequency-Test Output

This block turns a stream of oscillator enables, nominally 32,768 per second, into a one-clock seconds pulse and a one-clock minutes pulse. The division is not a fixed ratio. A calibration byte selects a magnitude and a direction. In selected minutes of a repeating correction cycle, one second is made shorter or longer so that crystal error can be trimmed in steps of a few parts per million.

The adjustment acts on the divide-by-256 stage. A speed-up removes one 256-enable period from the adjusted second. A slow-down lengthens one of its 256-enable periods by 128 enables. A separate 512 Hz square wave is derived ahead of the correction, so the calibration setting never moves it. That square wave is gated by a set of stop, test, alarm and watchdog control bits. A stop input freezes the whole chain.

The block runs on a system clock. `osc_en` marks each oscillator cycle. The count parameters are generic, so a bench can shrink the second, the minute and the cycle.

Top module: `rtc_cal_divider`

## Requirements
- R1: With no adjustment in force, a second lasts 256*PRE_DIV counted enables (32,768 by default); `sec_tick` is high for exactly the one clock after the edge that counts the last enable of the second. An enable counts only when `osc_en`=1 and `stop`=0 at a rising clock edge.
- R2: `min_tick` is high for one clock at the end of every SEC_PER_MIN-th second, always together with `sec_tick`.
- R3: The calibration byte has a magnitude N in bits 4..0 and a sign in bit 5 (1 = speed up, 0 = slow down). Bits 7..6 have no effect. The byte is sampled at the edge that ends each minute and applies to the following minute. The setting held after reset is N=0.
- R4: With a positive sign, the first second of each minute whose cycle position p satisfies p < 2N is 256 enables short.
- R5: With a negative sign, the first second of each eligible minute is 128 enables long.
- R6: The cycle position starts at 0, advances at each minute end and wraps from CYC_MIN-1 to 0. Only positions p < CYC_MIN-2 are ever eligible, whatever N is.
- R7: While `stop`=1, no counter advances. When `stop` returns to 0, counting resumes from where it halted.
- R8: `ft_out` is 1 only when `stop`=0, `ft_en`=1, `alarm_en`=0, either `wd_steer`=1 or `wd_zero`=1, and bit 5 of a free-running count of enables modulo 64 is 1. This gives 512 Hz at the nominal rate.
- R9: The phase and period of `ft_out` do not depend on the calibration byte.
- R10: A synchronous active-low reset clears every divider stage, the seconds index, the cycle position and the sampled calibration. `sec_tick`, `min_tick` and `ft_out` are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| osc_en | input | 1 | One-clock marker per oscillator cycle |
| stop | input | 1 | Freezes the divider chain when 1 |
| cal_byte | input | 8 | Calibration: bit 5 sign, bits 4..0 magnitude |
| ft_en | input | 1 | Frequency-test request |
| alarm_en | input | 1 | Alarm interrupt enable; blocks the test output |
| wd_steer | input | 1 | Watchdog routed to reset; frees the test output |
| wd_zero | input | 1 | Watchdog register is zero; frees the test output |
| sec_tick | output | 1 | One-clock pulse at each second end |
| min_tick | output | 1 | One-clock pulse at each minute end |
| ft_out | output | 1 | Gated 512 Hz test square wave |

## Verification
The assertions assume that PRE_DIV is at least 2, so that two seconds never end on adjacent clocks. They also assume that `stop` is a level sampled at the clock like any other input, rather than a glitching signal. The stimulus changes every input only between clock edges. It spaces `osc_en` irregularly but never faster than one enable per clock. It toggles `stop` in blocks of hundreds of clocks. It changes the calibration byte only at scenario boundaries, while the model latches the byte at the same minute edge as the design.

// File: rtl/rtc_cal_pkg.sv
// Package: shared constants and the decoded calibration type.
// Assumes the adjustment stage is 256 enables wide and a stretch adds half of it.
package rtc_cal_pkg;

    localparam int STAGE_LEN   = 256;
    localparam int STRETCH_ADD = 128;
    localparam int STAGE_W     = 9;
    localparam int FT_W        = 6;

    typedef struct packed {
        logic       speed_up;
        logic [4:0] mag;
    } cal_t;

    // Decode the calibration byte; the two top bits are unused.
    function automatic cal_t decode_cal(input logic [7:0] raw);
        cal_t c;
        c.speed_up = raw[5];
        c.mag      = raw[4:0];
        return c;
    endfunction

endpackage

// File: rtl/rtc_cal_prescale.sv
// Module: the 256-enable stage and the stage counter that forms one second.
// It assumes the adjust flags stay constant for the whole of a second.
// adj_short drops one stage period from the second.
// adj_long lengthens the first stage period of the second by STRETCH_ADD.
module rtc_cal_prescale
    import rtc_cal_pkg::*;
#(
    parameter int PRE_DIV = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    input  logic adj_short,
    input  logic adj_long,
    output logic sec_done
);
    localparam int B_W = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
    localparam logic [STAGE_W-1:0] LAST_NORM = STAGE_W'(STAGE_LEN - 1);
    localparam logic [STAGE_W-1:0] LAST_LONG = STAGE_W'(STAGE_LEN + STRETCH_ADD - 1);
    localparam logic [B_W-1:0]     B_FULL    = B_W'(PRE_DIV - 1);
    localparam logic [B_W-1:0]     B_SHORT   = B_W'(PRE_DIV - 2);

    logic [STAGE_W-1:0] cnt_a;
    logic [B_W-1:0]     cnt_b;
    logic               stretch;
    logic               end_a;
    logic               end_sec;

    // Pick the terminal counts for the current stage period and second.
    always_comb begin
        stretch = adj_long && (cnt_b == '0);
        end_a   = (cnt_a == (stretch ? LAST_LONG : LAST_NORM));
        end_sec = end_a && (cnt_b == (adj_short ? B_SHORT : B_FULL));
    end

    assign sec_done = adv && end_sec;

    // Advance the stage counter and the stage-period counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_a <= '0;
            cnt_b <= '0;
        end else if (adv) begin
            if (end_a) begin
                cnt_a <= '0;
                cnt_b <= end_sec ? '0 : cnt_b + 1'b1;
            end else begin
                cnt_a <= cnt_a + 1'b1;
            end
        end
    end

    p_stage_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_a <= LAST_LONG);
    p_hold_when_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(cnt_a) && $stable(cnt_b));

endmodule

// File: rtl/rtc_cal_sequencer.sv
// Module: the seconds-in-minute index, the position in the correction cycle
// and the calibration sampled at each minute end.
// It decides whether the current second is adjusted, and in which direction.
// It assumes sec_done is a single-clock pulse.
module rtc_cal_sequencer
    import rtc_cal_pkg::*;
#(
    parameter int SEC_PER_MIN = 60,
    parameter int CYC_MIN     = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sec_done,
    input  logic [7:0] cal_in,
    output logic       adj_short,
    output logic       adj_long,
    output logic       min_done
);
    localparam int S_W = (SEC_PER_MIN > 1) ? $clog2(SEC_PER_MIN) : 1;
    localparam int P_W = (CYC_MIN > 1) ? $clog2(CYC_MIN) : 1;
    localparam logic [S_W-1:0] S_LAST = S_W'(SEC_PER_MIN - 1);
    localparam logic [P_W-1:0] P_LAST = P_W'(CYC_MIN - 1);

    logic [S_W-1:0] sec_q;
    logic [P_W-1:0] pos_q;
    cal_t           cal_q;
    logic           eligible;

    assign min_done = sec_done && (sec_q == S_LAST);

    // Eligibility of this minute, which applies to its first second only.
    always_comb begin
        eligible  = (32'(pos_q) < 32'({cal_q.mag, 1'b0})) &&
                    (32'(pos_q) < 32'(CYC_MIN - 2));
        adj_short = eligible && (sec_q == '0) && cal_q.speed_up;
        adj_long  = eligible && (sec_q == '0) && !cal_q.speed_up;
    end

    // Step the seconds index; at a minute end, step the position and sample the calibration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_q <= '0;
            pos_q <= '0;
            cal_q <= '0;
        end else if (sec_done) begin
            sec_q <= (sec_q == S_LAST) ? '0 : sec_q + 1'b1;
            if (min_done) begin
                pos_q <= (pos_q == P_LAST) ? '0 : pos_q + 1'b1;
                cal_q <= decode_cal(cal_in);
            end
        end
    end

    p_adj_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({adj_short, adj_long}));
    p_pos_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        32'(pos_q) < 32'(CYC_MIN));
    p_pos_moves_on_minute_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !min_done |=> $stable(pos_q));

endmodule

// File: rtl/rtc_ft_gen.sv
// Module: the frequency-test square wave taken from an uncorrected enable count.
// Bit 5 of a 6-bit count gives a 64-enable period (512 Hz at 32,768 Hz).
// It assumes the gate inputs are static levels.
module rtc_ft_gen
    import rtc_cal_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    input  logic stop,
    input  logic ft_en,
    input  logic alarm_en,
    input  logic wd_steer,
    input  logic wd_zero,
    output logic ft_out
);
    logic [FT_W-1:0] ft_cnt;
    logic            gate;

    // Combine the control levels that allow the test output.
    always_comb begin
        gate   = !stop && ft_en && !alarm_en && (wd_steer || wd_zero);
        ft_out = gate && ft_cnt[FT_W-1];
    end

    // Free-running count of counted enables, outside the correction path.
    always_ff @(posedge clk) begin
        if (!rst_n) ft_cnt <= '0;
        else if (adv) ft_cnt <= ft_cnt + 1'b1;
    end

    p_ft_count_steps_r9: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> ft_cnt == $past(ft_cnt) + 1'b1);

endmodule

// File: rtl/rtc_cal_divider.sv
// Module (top): the calibrated seconds divider.
// It gates the oscillator enable with stop, wires the stage, the sequencer and
// the test-wave generator, and registers the second and minute pulses.
// It assumes PRE_DIV >= 2, SEC_PER_MIN >= 1 and CYC_MIN >= 3.
module rtc_cal_divider #(
    parameter int PRE_DIV     = 128,
    parameter int SEC_PER_MIN = 60,
    parameter int CYC_MIN     = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       osc_en,
    input  logic       stop,
    input  logic [7:0] cal_byte,
    input  logic       ft_en,
    input  logic       alarm_en,
    input  logic       wd_steer,
    input  logic       wd_zero,
    output logic       sec_tick,
    output logic       min_tick,
    output logic       ft_out
);
    logic adv;
    logic sec_done;
    logic min_done;
    logic adj_short;
    logic adj_long;

    assign adv = osc_en && !stop;

    rtc_cal_prescale #(.PRE_DIV(PRE_DIV)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv      (adv),
        .adj_short(adj_short),
        .adj_long (adj_long),
        .sec_done (sec_done)
    );

    rtc_cal_sequencer #(.SEC_PER_MIN(SEC_PER_MIN), .CYC_MIN(CYC_MIN)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .sec_done (sec_done),
        .cal_in   (cal_byte),
        .adj_short(adj_short),
        .adj_long (adj_long),
        .min_done (min_done)
    );

    rtc_ft_gen u_ft (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (adv),
        .stop    (stop),
        .ft_en   (ft_en),
        .alarm_en(alarm_en),
        .wd_steer(wd_steer),
        .wd_zero (wd_zero),
        .ft_out  (ft_out)
    );

    // Register the end-of-second and end-of-minute pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_tick <= 1'b0;
            min_tick <= 1'b0;
        end else begin
            sec_tick <= sec_done;
            min_tick <= min_done;
        end
    end

    p_min_with_sec_r2: assert property (@(posedge clk) disable iff (!rst_n)
        min_tick |-> sec_tick);
    p_single_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick |=> !sec_tick);
    p_ft_quiet_on_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stop |-> !ft_out);

endmodule

// File: tb/test_rtc_cal_divider.sv
module test_rtc_cal_divider;
    localparam int PRE = 2;
    localparam int SPM = 3;
    localparam int CYC = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_en = 1'b0;
    logic       stop = 1'b0;
    logic [7:0] cal_byte = 8'h00;
    logic       ft_en = 1'b1;
    logic       alarm_en = 1'b0;
    logic       wd_steer = 1'b1;
    logic       wd_zero = 1'b0;
    logic       sec_tick, min_tick, ft_out;

    int    n_checks = 0;
    int    n_fail = 0;
    int    n_clk = 0;
    bit    done = 1'b0;
    string tag = "R10";

    // behavioural model state
    int m_cyc = 0, m_sec = 0, m_pos = 0, m_mag = 0, m_ft = 0;
    bit m_sgn = 0, e_sec = 0, e_min = 0;

    always #2 clk = ~clk;

    rtc_cal_divider #(.PRE_DIV(PRE), .SEC_PER_MIN(SPM), .CYC_MIN(CYC)) i_rtc_cal_divider (
        .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .stop(stop), .cal_byte(cal_byte),
        .ft_en(ft_en), .alarm_en(alarm_en), .wd_steer(wd_steer), .wd_zero(wd_zero),
        .sec_tick(sec_tick), .min_tick(min_tick), .ft_out(ft_out)
    );

    function automatic int sec_len();
        bit elig = (m_sec == 0) && (m_pos < 2 * m_mag) && (m_pos < CYC - 2);
        if (!elig) return 256 * PRE;
        return m_sgn ? 256 * PRE - 256 : 256 * PRE + 128;
    endfunction

    // Reference model: enables, seconds, minutes, cycle position (R1..R7, R10).
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cyc = 0; m_sec = 0; m_pos = 0; m_mag = 0; m_sgn = 0; m_ft = 0;
            e_sec = 0; e_min = 0;
        end else begin
            int len;
            len = sec_len();
            e_sec = 0; e_min = 0;
            if (osc_en && !stop) begin
                m_ft = (m_ft + 1) % 64;
                m_cyc++;
                if (m_cyc == len) begin
                    m_cyc = 0; e_sec = 1;
                    if (m_sec == SPM - 1) begin
                        m_sec = 0; e_min = 1;
                        m_pos = (m_pos + 1) % CYC;
                        m_mag = int'(cal_byte[4:0]);
                        m_sgn = cal_byte[5];
                    end else begin
                        m_sec++;
                    end
                end
            end
        end
    end

    task automatic check1(input string what, input bit act, input bit exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0b expected %0b at clock %0d", tag, what, act, exp, n_clk);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // Compare every clock, away from the rising edge; the watchdog lives here too.
    always @(negedge clk) begin
        bit gate;
        n_clk++;
        if (!done) begin
            gate = !stop && ft_en && !alarm_en && (wd_steer || wd_zero);
            check1("sec_tick", sec_tick, e_sec);
            check1("min_tick", min_tick, e_min);
            check1("ft_out R8 R9", ft_out, gate && (m_ft >= 32));
        end
        if (n_clk > 190000 && !done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    task automatic run(input int n, input bit with_stop);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #1;
            osc_en = ((n_clk % 5) != 3) && ((n_clk % 17) != 9);
            if (with_stop) stop = ((i % 1000) >= 700);
        end
        @(negedge clk); #1;
        stop = 1'b0;
    endtask

    initial begin
        // R10: reset state
        tag = "R10";
        repeat (5) @(negedge clk);
        #1 rst_n = 1'b1;
        run(20, 1'b0);
        // R1 R2: nominal division, calibration zero
        tag = "R1 R2";
        run(16000, 1'b0);
        // R4 R3: speed up, N=2
        tag = "R4 R3";
        cal_byte = 8'h22;
        run(16000, 1'b0);
        // R5: slow down, N=1
        tag = "R5";
        cal_byte = 8'h01;
        run(16000, 1'b0);
        // R6 R3: N=31 with unused bits set, clipped by the eligible window
        tag = "R6 R3";
        cal_byte = 8'hDF;
        run(16000, 1'b0);
        tag = "R6 R5";
        cal_byte = 8'h1F;
        run(8000, 1'b0);
        // R7: stop bursts
        tag = "R7";
        cal_byte = 8'h23;
        run(5000, 1'b1);
        // R8 R9: gate combinations while the calibration changes
        tag = "R8 R9";
        for (int k = 0; k < 16; k++) begin
            ft_en = k[0]; alarm_en = k[1]; wd_steer = k[2]; wd_zero = k[3];
            cal_byte = 8'(k * 7);
            stop = (k == 5);
            run(250, 1'b0);
        end
        // R10: reset mid-run
        tag = "R10";
        ft_en = 1'b1; alarm_en = 1'b0; wd_steer = 1'b1;
        @(negedge clk); #1 rst_n = 1'b0;
        run(3, 1'b0);
        @(negedge clk); #1 rst_n = 1'b1;
        run(2000, 1'b0);
        done = 1'b1;
        summary();
    end
endmodule